// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Level Status

This block holds the two byte queues that sit between a UART's bus-facing data registers and its serial shifters. The transmit queue is filled by writes to the transmit data register and drained by the transmit shifter. The receive queue is filled by the receive shifter and drained by reads of the receive data register. Each queue has its own control word, which carries an enable, a self-clearing flush command and a trigger level. A single packed status word reports both fill levels and the free transmit space. A driver therefore sizes a burst of writes or reads from one status read.

Each queue is run by a four-state machine. OFF is the state while the queue is disabled. EMPTY holds no entries, PART holds between one and fifteen, and FULL holds sixteen. The transitions are as follows:
- OFF goes to EMPTY, or straight to PART if a push lands in the first enabled cycle.
- EMPTY goes to PART on a push.
- PART goes to FULL on a push without a pop at fifteen entries, and to EMPTY on a pop without a push at one entry.
- FULL goes to PART on a pop without a push.
- Clearing the enable sends any state to OFF.
- A flush sends any enabled state to EMPTY.

Two level-sensitive requests tell an interrupt controller when to service the queues. A one-cycle overrun pulse marks a received byte that was lost.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue accepts exactly 16 bytes; a push into a full queue with no pop in the same cycle is discarded, and the level stays at 16.
- R2: `fifo_status` carries the receive level in bits 5:0, the transmit level in bits 13:8 and the free transmit count in bits 29:24. All other bits read zero.
- R3: Writing a control word stores bit 0 as the enable and bits 13:8 as the trigger level. The readback shows those two fields, with every other bit zero.
- R4: A control write with bit 1 set empties that queue in the write cycle, ahead of any push or pop in the same cycle. Bit 1 always reads back as zero.
- R5: Bytes leave each queue in the order they entered. The head byte is shown on the read port while the queue is not empty, and 0x00 while it is empty.
- R6: The free transmit count equals 16 minus the transmit level while that queue is enabled, and is zero while it is disabled.
- R7: A receive push that R1 discards raises `rx_overrun` for exactly the next cycle. At no other time does `rx_overrun` go high.
- R8: `rx_req` is high exactly while the receive queue is enabled and its level is at or above its trigger level.
- R9: `tx_req` is high exactly while the transmit queue is enabled and its level is at or below its trigger level. `tx_empty` is high exactly when the reported transmit level is zero.
- R10: While a queue is disabled, it reports level zero, ignores pushes and pops, and keeps its request low. Its contents are discarded, so re-enabling it starts it empty.
- R11: A pop from an empty queue is ignored. A push and a pop in the same cycle on a full queue both take effect, and no overrun is raised.
- R12: After reset both queues are disabled and empty, both trigger levels are zero, and all outputs are zero except `tx_empty`, which is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ctl_we | input | 1 | Write strobe for the transmit control word |
| rx_ctl_we | input | 1 | Write strobe for the receive control word |
| ctl_wdata | input | 16 | Control write data (bit 0 enable, bit 1 flush, bits 13:8 trigger) |
| tx_ctl_q | output | 16 | Transmit control readback |
| rx_ctl_q | output | 16 | Receive control readback |
| tx_wr | input | 1 | Transmit data register write (push) |
| tx_wbyte | input | 8 | Byte to push into the transmit queue |
| tx_take | input | 1 | Transmit shifter takes the head byte (pop) |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_empty | output | 1 | Transmit level is zero |
| rx_put | input | 1 | Receive shifter delivers a byte (push) |
| rx_pbyte | input | 8 | Byte delivered by the receive shifter |
| rx_rd | input | 1 | Receive data register read (pop) |
| rx_byte | output | 8 | Head of the receive queue |
| fifo_status | output | 32 | Packed levels and free count |
| tx_req | output | 1 | Transmit threshold request |
| rx_req | output | 1 | Receive threshold request |
| rx_overrun | output | 1 | One-cycle pulse for a dropped receive byte |

## Verification
The bench drives a queue past sixteen entries and checks that the extra bytes are dropped and flagged. A queue that counted to seventeen, or wrapped its pointers, would corrupt the head byte and the status word. It then pushes and pops a full queue in the same cycle, pops an empty one, and issues a flush in the same cycle as a push. A design that ordered these events differently would leave a stray byte or raise a false overrun. It also disables a partly filled queue, pushes into it, and re-enables it. Stale bytes reappearing, or a request that stayed high while disabled, would show up as a level or head-byte mismatch. A long random phase then shifts both trigger levels around the current fill levels, which catches an off-by-one in either comparison.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int BYTE_W       = 8;
    localparam int FIELD_W      = 6;
    localparam int CTL_W        = 16;
    localparam int STAT_W       = 32;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int CTL_TRIG_LSB  = 8;
    localparam int ST_RXLVL_LSB  = 0;
    localparam int ST_TXLVL_LSB  = 8;
    localparam int ST_TXFREE_LSB = 24;

    typedef enum logic [1:0] {
        FS_OFF   = 2'd0,
        FS_EMPTY = 2'd1,
        FS_PART  = 2'd2,
        FS_FULL  = 2'd3
    } fifo_state_e;
endpackage

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
    import uart_fifo_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int CW = CTL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    output logic          en_q,
    output logic [FW-1:0] trig_q,
    output logic          flush,
    output logic [CW-1:0] rdback
);
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trig_q <= '0;
        end else if (we) begin
            en_q   <= wdata[CTL_EN_BIT];
            trig_q <= wdata[CTL_TRIG_LSB +: FW];
        end
    end

    assign flush = we & wdata[CTL_FLUSH_BIT];

    always_comb begin
        rdback = '0;
        rdback[CTL_EN_BIT] = en_q;
        rdback[CTL_TRIG_LSB +: FW] = trig_q;
    end

    // R4: the flush command bit never appears in the readback
    a_r4_flush_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdback[CTL_FLUSH_BIT] == 1'b0));
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = BYTE_W,
    parameter int LW    = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    fifo_state_e   st, st_nx;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_pop  = en & ~flush & pop & (cnt != '0);
    assign do_push = en & ~flush & push & ((cnt != FULL_CNT) | do_pop);

    always_comb begin
        st_nx = st;
        if (!en) begin
            st_nx = FS_OFF;
        end else if (flush) begin
            st_nx = FS_EMPTY;
        end else begin
            unique case (st)
                FS_OFF:   st_nx = do_push ? FS_PART : FS_EMPTY;
                FS_EMPTY: st_nx = do_push ? FS_PART : FS_EMPTY;
                FS_PART: begin
                    if (do_push && !do_pop && cnt == FULL_CNT - 1'b1)
                        st_nx = FS_FULL;
                    else if (do_pop && !do_push && cnt == LW'(1))
                        st_nx = FS_EMPTY;
                    else
                        st_nx = FS_PART;
                end
                FS_FULL:  st_nx = (do_pop && !do_push) ? FS_PART : FS_FULL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            wp  <= '0;
            rp  <= '0;
        end else if (!en || flush) begin
            cnt <= '0;
            wp  <= '0;
            rp  <= '0;
        end else begin
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
            if (do_push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_comb begin
        level = '0;
        head  = '0;
        unique case (st)
            FS_OFF:   level = '0;
            FS_EMPTY: level = '0;
            FS_PART:  level = cnt;
            FS_FULL:  level = FULL_CNT;
        endcase
        if (!en) level = '0;
        if (level != '0) head = mem[rp];
    end

    // R1: the entry count never exceeds the depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    // R11: the state register agrees with the counter
    a_r11_state_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == FS_FULL) |-> (cnt == FULL_CNT)) and ((st == FS_EMPTY) |-> (cnt == '0)));
    // R10: a disabled queue is emptied and parked in OFF
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == FS_OFF && cnt == '0));
    // R4: a flush on an enabled queue leaves it empty
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && en) |=> (cnt == '0));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_ctl_we,
    input  logic                 rx_ctl_we,
    input  logic [CTL_W-1:0]     ctl_wdata,
    output logic [CTL_W-1:0]     tx_ctl_q,
    output logic [CTL_W-1:0]     rx_ctl_q,
    input  logic                 tx_wr,
    input  logic [BYTE_W-1:0]    tx_wbyte,
    input  logic                 tx_take,
    output logic [BYTE_W-1:0]    tx_byte,
    output logic                 tx_empty,
    input  logic                 rx_put,
    input  logic [BYTE_W-1:0]    rx_pbyte,
    input  logic                 rx_rd,
    output logic [BYTE_W-1:0]    rx_byte,
    output logic [STAT_W-1:0]    fifo_status,
    output logic                 tx_req,
    output logic                 rx_req,
    output logic                 rx_overrun
);
    localparam logic [FIELD_W-1:0] FULL_LVL = FIELD_W'(DEPTH);

    logic               tx_en, rx_en, tx_flush, rx_flush;
    logic [FIELD_W-1:0] tx_trig, rx_trig, tx_level, rx_level, tx_free;
    logic               rx_lost, ovr_q;

    fifo_ctl_reg #(.FW(FIELD_W), .CW(CTL_W)) u_tx_ctl (
        .clk(clk), .rst_n(rst_n), .we(tx_ctl_we), .wdata(ctl_wdata),
        .en_q(tx_en), .trig_q(tx_trig), .flush(tx_flush), .rdback(tx_ctl_q)
    );

    fifo_ctl_reg #(.FW(FIELD_W), .CW(CTL_W)) u_rx_ctl (
        .clk(clk), .rst_n(rst_n), .we(rx_ctl_we), .wdata(ctl_wdata),
        .en_q(rx_en), .trig_q(rx_trig), .flush(rx_flush), .rdback(rx_ctl_q)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W), .LW(FIELD_W)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .flush(tx_flush),
        .push(tx_wr), .push_data(tx_wbyte), .pop(tx_take),
        .head(tx_byte), .level(tx_level)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W), .LW(FIELD_W)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .flush(rx_flush),
        .push(rx_put), .push_data(rx_pbyte), .pop(rx_rd),
        .head(rx_byte), .level(rx_level)
    );

    assign tx_free = tx_en ? (FULL_LVL - tx_level) : '0;

    always_comb begin
        fifo_status = '0;
        fifo_status[ST_RXLVL_LSB  +: FIELD_W] = rx_level;
        fifo_status[ST_TXLVL_LSB  +: FIELD_W] = tx_level;
        fifo_status[ST_TXFREE_LSB +: FIELD_W] = tx_free;
    end

    assign rx_lost = rx_put & rx_en & ~rx_flush & ~rx_rd & (rx_level == FULL_LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= rx_lost;
    end

    assign rx_overrun = ovr_q;
    assign rx_req     = rx_en & (rx_level >= rx_trig);
    assign tx_req     = tx_en & (tx_level <= tx_trig);
    assign tx_empty   = (tx_level == '0);

    // R7: an overrun pulse follows only a cycle in which the receive queue was full
    a_r7_overrun_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_level) == FULL_LVL));
    // R6: free space plus fill level covers the whole depth while enabled
    a_r6_free_plus_level: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> ((tx_free + tx_level) == FULL_LVL));
    // R10: a disabled queue keeps its request low
    a_r10_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en |-> !rx_req) and (!tx_en |-> !tx_req));
endmodule

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_ctl_we = 1'b0, rx_ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] tx_ctl_q, rx_ctl_q;
    logic        tx_wr = 1'b0, tx_take = 1'b0, rx_put = 1'b0, rx_rd = 1'b0;
    logic [7:0]  tx_wbyte = '0, rx_pbyte = '0;
    logic [7:0]  tx_byte, rx_byte;
    logic        tx_empty, tx_req, rx_req, rx_overrun;
    logic [31:0] fifo_status;

    int vectors = 0;
    int errors  = 0;

    logic [7:0] mq_tx[$];
    logic [7:0] mq_rx[$];
    logic       m_tx_en, m_rx_en, m_ovr;
    int         m_tx_trig, m_rx_trig;

    always #10 clk = ~clk;

    uart_fifo_pair i_uart_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .tx_ctl_we(tx_ctl_we), .rx_ctl_we(rx_ctl_we), .ctl_wdata(ctl_wdata),
        .tx_ctl_q(tx_ctl_q), .rx_ctl_q(rx_ctl_q),
        .tx_wr(tx_wr), .tx_wbyte(tx_wbyte), .tx_take(tx_take),
        .tx_byte(tx_byte), .tx_empty(tx_empty),
        .rx_put(rx_put), .rx_pbyte(rx_pbyte), .rx_rd(rx_rd), .rx_byte(rx_byte),
        .fifo_status(fifo_status), .tx_req(tx_req), .rx_req(rx_req),
        .rx_overrun(rx_overrun)
    );

    // Behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mq_tx.delete(); mq_rx.delete();
            m_tx_en = 0; m_rx_en = 0; m_tx_trig = 0; m_rx_trig = 0; m_ovr = 0;
        end else begin
            logic fl_t, fl_r, popped;
            fl_t = tx_ctl_we && ctl_wdata[1];
            fl_r = rx_ctl_we && ctl_wdata[1];
            if (!m_tx_en || fl_t) mq_tx.delete();
            else begin
                if (tx_take && mq_tx.size() > 0) void'(mq_tx.pop_front());
                if (tx_wr && mq_tx.size() < 16) mq_tx.push_back(tx_wbyte);
            end
            m_ovr = 0;
            if (!m_rx_en || fl_r) mq_rx.delete();
            else begin
                popped = 0;
                if (rx_rd && mq_rx.size() > 0) begin void'(mq_rx.pop_front()); popped = 1; end
                if (rx_put) begin
                    if (mq_rx.size() < 16) mq_rx.push_back(rx_pbyte);
                    else if (!popped) m_ovr = 1;
                end
            end
            if (tx_ctl_we) begin m_tx_en = ctl_wdata[0]; m_tx_trig = int'(ctl_wdata[13:8]); end
            if (rx_ctl_we) begin m_rx_en = ctl_wdata[0]; m_rx_trig = int'(ctl_wdata[13:8]); end
        end
    end

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int txl, rxl, fr;
        logic [31:0] st;
        txl = m_tx_en ? mq_tx.size() : 0;
        rxl = m_rx_en ? mq_rx.size() : 0;
        fr  = m_tx_en ? 16 - txl : 0;
        st = '0;
        st[5:0] = 6'(rxl); st[13:8] = 6'(txl); st[29:24] = 6'(fr);
        expect_eq("R2 status", fifo_status, st);
        expect_eq("R5 tx head", 32'(tx_byte), (txl > 0) ? 32'(mq_tx[0]) : 32'd0);
        expect_eq("R5 rx head", 32'(rx_byte), (rxl > 0) ? 32'(mq_rx[0]) : 32'd0);
        expect_eq("R9 tx_empty", 32'(tx_empty), 32'(txl == 0));
        expect_eq("R9 tx_req", 32'(tx_req), 32'(m_tx_en && txl <= m_tx_trig));
        expect_eq("R8 rx_req", 32'(rx_req), 32'(m_rx_en && rxl >= m_rx_trig));
        expect_eq("R7 overrun", 32'(rx_overrun), 32'(m_ovr));
        expect_eq("R3 tx ctl", 32'(tx_ctl_q), {16'd0, 2'b00, 6'(m_tx_trig), 7'd0, m_tx_en});
        expect_eq("R3 rx ctl", 32'(rx_ctl_q), {16'd0, 2'b00, 6'(m_rx_trig), 7'd0, m_rx_en});
    endtask

    task automatic step(input logic twr, input logic [7:0] tb, input logic tk,
                        input logic rp, input logic [7:0] pb, input logic rr,
                        input logic twe, input logic rwe, input logic [15:0] wd);
        tx_wr = twr; tx_wbyte = tb; tx_take = tk;
        rx_put = rp; rx_pbyte = pb; rx_rd = rr;
        tx_ctl_we = twe; rx_ctl_we = rwe; ctl_wdata = wd;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        expect_eq("R12 status", fifo_status, 32'd0);
        expect_eq("R12 tx_empty", 32'(tx_empty), 32'd1);
        expect_eq("R12 reqs", {30'd0, tx_req, rx_req}, 32'd0);
        expect_eq("R12 ctl", {tx_ctl_q, rx_ctl_q}, 32'd0);
        check_all();

        // enable both queues, trigger level 4
        step(0, 8'h00, 0, 0, 8'h00, 0, 1, 1, 16'h0401);

        // R1 and R7: overfill the receive queue
        for (int i = 0; i < 18; i++) step(0, 8'h00, 0, 1, 8'(8'h30 + i), 0, 0, 0, 16'h0);
        expect_eq("R1 rx level full", 32'(fifo_status[5:0]), 32'd16);
        expect_eq("R7 overrun after drop", 32'(rx_overrun), 32'd1);
        idle();
        expect_eq("R7 overrun single", 32'(rx_overrun), 32'd0);

        // R11: push and pop together on a full queue
        step(0, 8'h00, 0, 1, 8'hAA, 1, 0, 0, 16'h0);
        expect_eq("R11 full push+pop level", 32'(fifo_status[5:0]), 32'd16);
        expect_eq("R11 no overrun", 32'(rx_overrun), 32'd0);
        expect_eq("R5 order", 32'(rx_byte), 32'h31);

        // drain, then pop on empty
        for (int i = 0; i < 17; i++) step(0, 8'h00, 0, 0, 8'h00, 1, 0, 0, 16'h0);
        expect_eq("R11 empty pop level", 32'(fifo_status[5:0]), 32'd0);
        expect_eq("R5 empty head", 32'(rx_byte), 32'd0);

        // R6: fill transmit queue past its depth
        for (int i = 0; i < 17; i++) step(1, 8'(8'hC0 + i), 0, 0, 8'h00, 0, 0, 0, 16'h0);
        expect_eq("R6 free zero", 32'(fifo_status[29:24]), 32'd0);
        expect_eq("R1 tx level", 32'(fifo_status[13:8]), 32'd16);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0, 8'h00, 0, 0, 0, 16'h0);
        expect_eq("R6 free after takes", 32'(fifo_status[29:24]), 32'd5);

        // R4: flush with a push in the same cycle
        for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 1, 8'(i), 0, 0, 0, 16'h0);
        step(0, 8'h00, 0, 1, 8'h77, 0, 0, 1, 16'h0403);
        expect_eq("R4 flushed level", 32'(fifo_status[5:0]), 32'd0);
        expect_eq("R4 flush reads zero", 32'(rx_ctl_q[1]), 32'd0);

        // R10: disable a partly filled queue, push into it, re-enable
        step(0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 16'h0400);
        expect_eq("R10 disabled level", 32'(fifo_status[13:8]), 32'd0);
        step(1, 8'h55, 0, 0, 8'h00, 0, 0, 0, 16'h0);
        step(1, 8'h56, 0, 0, 8'h00, 0, 0, 0, 16'h0);
        expect_eq("R10 push ignored", 32'(fifo_status[13:8]), 32'd0);
        expect_eq("R10 req low", 32'(tx_req), 32'd0);
        step(0, 8'h00, 0, 0, 8'h00, 0, 1, 0, 16'h0401);
        expect_eq("R10 restart empty", 32'(fifo_status[13:8]), 32'd0);
        expect_eq("R10 free restored", 32'(fifo_status[29:24]), 32'd16);

        // random traffic with occasional control writes
        for (int i = 0; i < 3000; i++) begin
            logic twe, rwe;
            logic [15:0] wd;
            twe = ($urandom_range(0, 99) < 2);
            rwe = ($urandom_range(0, 99) < 2);
            wd  = '0;
            wd[0] = ($urandom_range(0, 9) != 0);
            wd[1] = ($urandom_range(0, 9) == 0);
            wd[13:8] = 6'($urandom_range(0, 20));
            wd[7:2] = 6'($urandom);
            step($urandom_range(0, 9) < 6, 8'($urandom), $urandom_range(0, 9) < 4,
                 $urandom_range(0, 9) < 6, 8'($urandom), $urandom_range(0, 9) < 4,
                 twe, rwe, wd);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule